// File: doc/BRIEF.md
# Hierarchical Depth Culling Unit

This unit sits in front of pixel shading and decides which pixels of an incoming primitive tile can still be seen. The screen is divided into 8x8 pixel tiles, and for every tile the unit keeps depth at three resolutions. The finest level holds one depth per pixel. The middle level holds the farthest depth of each 2x2 block. The coarsest level holds the farthest depth of each 4x4 block. A request names a tile, a 64-bit coverage mask and one nearest-depth value for the primitive. The unit tests the four coarse blocks first, then the 2x2 blocks inside the coarse blocks that survived, then the pixels inside the surviving 2x2 blocks. It returns the mask of surviving pixels, writes the request depth into those pixels, and recomputes both coarse levels for the tile before it takes the next request.

A second request kind resets every level of one tile to the maximum depth code in a single working cycle. This is how a tile is cleared at the start of a frame.

The control is a six-state machine:
- S_IDLE accepts work.
- S_COARSE tests the 4x4 blocks.
- S_MID tests the 2x2 blocks.
- S_FINE tests the pixels and writes the survivors.
- S_REFRESH rebuilds the coarse entries and presents the result.
- S_CLEAR resets a tile.

The transitions are:
- S_IDLE goes to S_COARSE on an accepted depth request and to S_CLEAR on an accepted clear.
- S_COARSE goes to S_MID, S_MID to S_FINE, and S_FINE to S_REFRESH.
- S_REFRESH and S_CLEAR both return to S_IDLE.

Top module: `hdc_cull`

## Requirements
- R1: After reset every stored depth of every tile equals 16'hFFFF, `req_ready` is 1 and `out_valid` is 0.
- R2: `req_ready` is 1 only while the unit is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1.
- R3: For an accepted depth request (`req_clear`=0), `out_valid` is 1 for exactly one cycle. That cycle is the fourth cycle after the accepting edge, and `out_mask` is valid in it.
- R4: Bit p of `out_mask` covers pixel row p/8 and column p%8 of the tile. The bit is 1 exactly when coverage bit p is 1 and the request depth is strictly less than the pixel's stored depth. An equal depth is rejected.
- R5: A surviving pixel's stored depth becomes the request depth. Every other pixel keeps its stored depth.
- R6: The 2x2 and 4x4 levels hold the farthest depth of the pixels beneath them. They are rebuilt within the same request, so a later request yields exactly the per-pixel result of R4 with no pixel lost.
- R7: An accepted clear (`req_clear`=1) sets every level of the addressed tile to 16'hFFFF. It produces no `out_valid`, and `req_ready` returns to 1 on the second edge after acceptance.
- R8: The tile address is `req_ty`*FRAME_W_TILES+`req_tx`. A request with `req_tx` >= FRAME_W_TILES or `req_ty` >= FRAME_H_TILES returns an all-zero mask and changes no stored depth. A clear addressed this way is ignored.
- R9: Uncovered pixels never survive and are never written.
- R10: Tiles are independent: a request changes only the depths of its own tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_clear | input | 1 | 1 = fast tile clear, 0 = depth test |
| req_tx | input | 3 | Tile column in the frame |
| req_ty | input | 3 | Tile row in the frame |
| req_cover | input | 64 | Coverage mask, bit = row*8+column |
| req_z | input | 16 | Nearest depth of the primitive |
| out_valid | output | 1 | Surviving mask present |
| out_mask | output | 64 | Pixels that go on to shading |

## Verification
The bench builds the unit with a frame of three tile columns and two tile rows. This makes the address non-square, so a row/column swap in the address arithmetic is detected. Six of the 64 index pairs are inside the frame. The rest exercise the out-of-frame path for both coordinates, including a column index that fits in a power-of-two frame but not in this one. Depths are drawn from a narrow range so that repeated requests to the same tile hit the equal-depth rejection and the coarse-reject path. Occasional clears then restore whole tiles to the maximum code.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
    localparam int TILE_DIM = 8;
    localparam int PIX_N    = TILE_DIM * TILE_DIM;
    localparam int B2_N     = PIX_N / 4;
    localparam int B4_N     = PIX_N / 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COARSE,
        S_MID,
        S_FINE,
        S_REFRESH,
        S_CLEAR
    } hdc_state_e;
endpackage

// File: rtl/hdc_max4.sv
module hdc_max4 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] y
);
    logic [W-1:0] ab, cd;
    assign ab = (a > b) ? a : b;
    assign cd = (c > d) ? c : d;
    assign y  = (ab > cd) ? ab : cd;
endmodule

// File: rtl/hdc_lt_vec.sv
module hdc_lt_vec #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic [N*W-1:0] stored,
    input  logic [W-1:0]   z,
    output logic [N-1:0]   lt
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign lt[i] = z < stored[i*W +: W];
    end
endmodule

// File: rtl/hdc_cull.sv
module hdc_cull
    import hdc_pkg::*;
#(
    parameter int FRAME_W_TILES = 2,
    parameter int FRAME_H_TILES = 2,
    parameter int Z_W           = 16,
    parameter int IDX_W         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_clear,
    input  logic [IDX_W-1:0] req_tx,
    input  logic [IDX_W-1:0] req_ty,
    input  logic [PIX_N-1:0] req_cover,
    input  logic [Z_W-1:0]   req_z,
    output logic             out_valid,
    output logic [PIX_N-1:0] out_mask
);
    localparam int TILES   = FRAME_W_TILES * FRAME_H_TILES;
    localparam int TILE_AW = (TILES > 1) ? $clog2(TILES) : 1;
    localparam logic [Z_W-1:0] Z_FAR = '1;

    hdc_state_e state, state_d;

    logic [Z_W-1:0] pix_mem [TILES][PIX_N];
    logic [Z_W-1:0] l2_mem  [TILES][B2_N];
    logic [Z_W-1:0] l4_mem  [TILES][B4_N];

    logic [TILE_AW-1:0] tile_q, req_addr;
    logic [Z_W-1:0]     z_q;
    logic [PIX_N-1:0]   cov_q;
    logic               in_frame_q, req_in_frame;
    logic [B4_N-1:0]    alive4_q, alive4_d, any4;
    logic [B2_N-1:0]    alive2_q, alive2_d, any2;
    logic [PIX_N-1:0]   surv_d;

    logic [PIX_N*Z_W-1:0] cur_pix;
    logic [B2_N*Z_W-1:0]  cur_l2, new_l2;
    logic [B4_N*Z_W-1:0]  cur_l4, new_l4;
    logic [PIX_N-1:0]     lt_pix;
    logic [B2_N-1:0]      lt2;
    logic [B4_N-1:0]      lt4;

    wire accept = req_valid && req_ready;

    assign req_ready    = (state == S_IDLE);
    assign req_in_frame = (int'(req_tx) < FRAME_W_TILES) && (int'(req_ty) < FRAME_H_TILES);
    assign req_addr     = TILE_AW'(int'(req_ty) * FRAME_W_TILES + int'(req_tx));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:    if (accept) state_d = req_clear ? S_CLEAR : S_COARSE;
            S_COARSE:  state_d = S_MID;
            S_MID:     state_d = S_FINE;
            S_FINE:    state_d = S_REFRESH;
            S_REFRESH: state_d = S_IDLE;
            S_CLEAR:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Read views of the current tile
    always_comb begin
        for (int p = 0; p < PIX_N; p++) cur_pix[p*Z_W +: Z_W] = pix_mem[tile_q][p];
        for (int k = 0; k < B2_N; k++)  cur_l2[k*Z_W +: Z_W]  = l2_mem[tile_q][k];
        for (int j = 0; j < B4_N; j++)  cur_l4[j*Z_W +: Z_W]  = l4_mem[tile_q][j];
    end

    hdc_lt_vec #(.N(B4_N),  .W(Z_W)) u_lt4 (.stored(cur_l4),  .z(z_q), .lt(lt4));
    hdc_lt_vec #(.N(B2_N),  .W(Z_W)) u_lt2 (.stored(cur_l2),  .z(z_q), .lt(lt2));
    hdc_lt_vec #(.N(PIX_N), .W(Z_W)) u_ltp (.stored(cur_pix), .z(z_q), .lt(lt_pix));

    // Coverage reduction and the coarse-to-fine walk
    always_comb begin
        any4 = '0;
        any2 = '0;
        for (int p = 0; p < PIX_N; p++) begin
            if (cov_q[p]) begin
                any4[(p/32)*2 + (p%8)/4] = 1'b1;
                any2[(p/16)*4 + (p%8)/2] = 1'b1;
            end
        end
        for (int j = 0; j < B4_N; j++)
            alive4_d[j] = in_frame_q && any4[j] && lt4[j];
        for (int k = 0; k < B2_N; k++)
            alive2_d[k] = alive4_q[(k/8)*2 + (k%4)/2] && any2[k] && lt2[k];
        for (int p = 0; p < PIX_N; p++)
            surv_d[p] = cov_q[p] && alive2_q[(p/16)*4 + (p%8)/2] && lt_pix[p];
    end

    // Farthest-depth rebuild from the pixel level upward
    for (genvar k = 0; k < B2_N; k++) begin : g_l2
        localparam int R = (k / 4) * 2;
        localparam int C = (k % 4) * 2;
        hdc_max4 #(.W(Z_W)) u_max (
            .a(cur_pix[(R*8 + C)*Z_W       +: Z_W]),
            .b(cur_pix[(R*8 + C + 1)*Z_W   +: Z_W]),
            .c(cur_pix[(R*8 + C + 8)*Z_W   +: Z_W]),
            .d(cur_pix[(R*8 + C + 9)*Z_W   +: Z_W]),
            .y(new_l2[k*Z_W +: Z_W])
        );
    end
    for (genvar j = 0; j < B4_N; j++) begin : g_l4
        localparam int R = (j / 2) * 2;
        localparam int C = (j % 2) * 2;
        hdc_max4 #(.W(Z_W)) u_max (
            .a(new_l2[(R*4 + C)*Z_W     +: Z_W]),
            .b(new_l2[(R*4 + C + 1)*Z_W +: Z_W]),
            .c(new_l2[(R*4 + C + 4)*Z_W +: Z_W]),
            .d(new_l2[(R*4 + C + 5)*Z_W +: Z_W]),
            .y(new_l4[j*Z_W +: Z_W])
        );
    end

    // Request capture and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tile_q     <= '0;
            z_q        <= '0;
            cov_q      <= '0;
            in_frame_q <= 1'b0;
            alive4_q   <= '0;
            alive2_q   <= '0;
        end else begin
            if (accept) begin
                tile_q     <= req_in_frame ? req_addr : '0;
                z_q        <= req_z;
                cov_q      <= req_cover;
                in_frame_q <= req_in_frame;
            end
            if (state == S_COARSE) alive4_q <= alive4_d;
            if (state == S_MID)    alive2_q <= alive2_d;
        end
    end

    // Depth store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TILES; t++) begin
                for (int p = 0; p < PIX_N; p++) pix_mem[t][p] <= Z_FAR;
                for (int k = 0; k < B2_N; k++)  l2_mem[t][k]  <= Z_FAR;
                for (int j = 0; j < B4_N; j++)  l4_mem[t][j]  <= Z_FAR;
            end
        end else begin
            if (state == S_FINE) begin
                for (int p = 0; p < PIX_N; p++)
                    if (surv_d[p]) pix_mem[tile_q][p] <= z_q;
            end
            if (state == S_REFRESH && in_frame_q) begin
                for (int k = 0; k < B2_N; k++) l2_mem[tile_q][k] <= new_l2[k*Z_W +: Z_W];
                for (int j = 0; j < B4_N; j++) l4_mem[tile_q][j] <= new_l4[j*Z_W +: Z_W];
            end
            if (state == S_CLEAR && in_frame_q) begin
                for (int p = 0; p < PIX_N; p++) pix_mem[tile_q][p] <= Z_FAR;
                for (int k = 0; k < B2_N; k++)  l2_mem[tile_q][k]  <= Z_FAR;
                for (int j = 0; j < B4_N; j++)  l4_mem[tile_q][j]  <= Z_FAR;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
        end else begin
            out_valid <= (state == S_FINE);
            if (state == S_FINE) out_mask <= surv_d;
        end
    end
endmodule

// File: rtl/hdc_cull_chk.sv
module hdc_cull_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_clear,
    input logic        out_valid,
    input logic [63:0] out_mask,
    input logic [63:0] cov_q,
    input logic        in_frame_q
);
    // R2
    busy_when_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);
    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_clear) |=> ##3 out_valid);
    // R7
    clear_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_clear) |=> (!req_ready && !out_valid) ##1 req_ready);
    // R9
    covered_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & ~cov_q) == 64'd0));
    // R8
    off_frame_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_frame_q) |-> (out_mask == 64'd0));
endmodule

bind hdc_cull hdc_cull_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_clear  (req_clear),
    .out_valid  (out_valid),
    .out_mask   (out_mask),
    .cov_q      (cov_q),
    .in_frame_q (in_frame_q)
);

// File: tb/hdc_cull_tb.sv
module hdc_cull_tb;
    localparam int FW = 3;
    localparam int FH = 2;
    localparam int NT = FW * FH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_clear = 1'b0;
    logic [2:0]  req_tx = '0;
    logic [2:0]  req_ty = '0;
    logic [63:0] req_cover = '0;
    logic [15:0] req_z = '0;
    logic        out_valid;
    logic [63:0] out_mask;

    int errors = 0;
    int checks = 0;
    logic [15:0] model [NT][64];

    always #4 clk = ~clk;

    hdc_cull #(.FRAME_W_TILES(FW), .FRAME_H_TILES(FH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_clear(req_clear), .req_tx(req_tx), .req_ty(req_ty),
        .req_cover(req_cover), .req_z(req_z), .out_valid(out_valid),
        .out_mask(out_mask)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_frame(input int tx, input int ty);
        return tx < FW && ty < FH;
    endfunction

    function automatic logic [63:0] expect_mask(input int tx, input int ty,
                                                input logic [63:0] cov, input logic [15:0] z);
        logic [63:0] m = '0;
        if (!in_frame(tx, ty)) return m;
        for (int p = 0; p < 64; p++)
            m[p] = cov[p] && (z < model[ty*FW + tx][p]);
        return m;
    endfunction

    task automatic handshake(input bit clr, input int tx, input int ty,
                             input logic [63:0] cov, input logic [15:0] z);
        req_valid = 1'b1; req_clear = clr; req_tx = 3'(tx); req_ty = 3'(ty);
        req_cover = cov; req_z = z;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R3 R4 R5 R6 R8 R9 R10: one depth request, compared with the flat per-pixel model
    task automatic depth_req(input int tx, input int ty, input logic [63:0] cov,
                             input logic [15:0] z, input string tag);
        logic [63:0] exp;
        bit early;
        exp = expect_mask(tx, ty, cov, z);
        handshake(1'b0, tx, ty, cov, z);
        early = out_valid;
        @(negedge clk); early |= out_valid;
        @(negedge clk); early |= out_valid;
        @(negedge clk);
        check(!early && out_valid, {tag, " R3 out_valid timing"}, 64'(out_valid), 64'd1);
        check(out_mask == exp, tag, out_mask, exp);
        if (in_frame(tx, ty))
            for (int p = 0; p < 64; p++)
                if (exp[p]) model[ty*FW + tx][p] = z;
        @(negedge clk);
        check(!out_valid, {tag, " R3 single pulse"}, 64'(out_valid), 64'd0);
    endtask

    // R7: tile clear
    task automatic clear_req(input int tx, input int ty);
        handshake(1'b1, tx, ty, '0, '0);
        check(!req_ready && !out_valid, "R7 busy during clear", 64'(req_ready), 64'd0);
        @(negedge clk);
        check(req_ready && !out_valid, "R7 ready after clear", 64'(req_ready), 64'd1);
        if (in_frame(tx, ty))
            for (int p = 0; p < 64; p++) model[ty*FW + tx][p] = 16'hFFFF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < NT; t++)
            for (int p = 0; p < 64; p++) model[t][p] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(req_ready && !out_valid, "R1 reset outputs", {62'd0, req_ready, out_valid}, 64'd2);

        // R1 R4: equal depth against cleared store is rejected
        depth_req(0, 0, '1, 16'hFFFF, "R1 R4 equal-to-max rejected");
        depth_req(0, 0, '1, 16'hFFFE, "R4 full tile passes");
        // R6: coarse blocks now all 16'hFFFE, z equal rejects everything
        depth_req(0, 0, '1, 16'hFFFE, "R6 coarse reject on equal");
        // R5 R6: one 4x4 block made near, then a mid depth only passes elsewhere
        depth_req(0, 0, 64'h0000_0000_0F0F_0F0F, 16'h0100, "R5 partial write");
        depth_req(0, 0, '1, 16'h0200, "R6 refreshed coarse levels");
        // R9: uncovered pixels of a fresh tile
        depth_req(2, 1, 64'h8000_0000_0000_0001, 16'h0010, "R9 corner coverage");
        // R10: neighbouring tile untouched
        depth_req(1, 1, '1, 16'h0010, "R10 independent tile");
        // R8: out-of-frame column (fits a 4-wide frame) and row
        depth_req(3, 0, '1, 16'h0000, "R8 column out of frame");
        depth_req(0, 5, '1, 16'h0000, "R8 row out of frame");
        clear_req(7, 7);
        // R7
        clear_req(0, 0);
        depth_req(0, 0, '1, 16'hFFFE, "R7 tile restored to far");

        for (int n = 0; n < 400; n++) begin
            int tx, ty;
            logic [63:0] cov;
            logic [15:0] z;
            tx = ($urandom % 8 == 0) ? int'($urandom % 8) : int'($urandom % FW);
            ty = ($urandom % 8 == 0) ? int'($urandom % 8) : int'($urandom % FH);
            cov = {$urandom, $urandom} & {$urandom, $urandom};
            z = 16'h4000 + 16'($urandom % 48) - 16'(n * 8);
            if ($urandom % 25 == 0) clear_req(tx, ty);
            else depth_req(tx, ty, cov, z, "R4 R5 R6 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule